// File: doc/BRIEF.md
# Peripheral Stop and Freeze Controller

This block is the module-level control wrapper of a serial peripheral attached to an internal register bus. It holds one 16-bit configuration word with a stop-enable bit, a freeze-enable bit, a supervisor-only bit and a 4-bit interrupt arbitration number. From these bits it drives the clock enable of the peripheral's logic, raises a halt request toward the serial engine, and decides which bus accesses are acknowledged and forwarded.

The halt request combines a debug-freeze input, which counts only when freeze is enabled, with an external software-halt input. The engine reports transfer boundaries. Once a boundary arrives while a halt is requested, the block reports itself halted and holds the serial output pins at their last values. It resumes without software action when the request goes away.

While stopped, forwarded reads are suppressed and return zero. Writes are still forwarded to the peripheral's registers and RAM. The configuration word itself can always be read. With supervisor-only mode set, user-mode accesses receive no acknowledge at all, which leaves the cycle to external handling.

Top module: `pstop_ctl`

## Requirements
- R1: After reset the configuration word reads 0x0080 (only the supervisor-only bit set), clk_en is 1, and halt_req, halted and bus_ack are 0.
- R2: A permitted write to the configuration address (CFG_ADDR, default 0) stores bit 15 (stop), bit 14 (freeze enable), bit 7 (supervisor-only) and bits 3..0 (arbitration number). Bits 13..8 and 6..4 always read back as 0.
- R3: clk_en equals the inverse of the stored stop bit. It falls in the cycle after a write that sets bit 15, and it returns to 1 after a write that clears bit 15 or after reset.
- R4: While stop is set, a read of any non-configuration address keeps periph_rd_en at 0 and is acknowledged with read data 0. Configuration reads still return the stored word.
- R5: While stop is set, a permitted write to a non-configuration address still drives periph_wr_en high in the same cycle as bus_sel.
- R6: When freeze enable is 1 and freeze_in is 1, halt_req is 1 in the same cycle. halted becomes 1 at the clock edge where halt_req and xfer_bnd are both 1, and it stays 1 while halt_req stays 1.
- R7: With freeze enable 0, freeze_in has no effect: halt_req and halted stay 0 even when xfer_bnd is 1.
- R8: While halted, pins_out keeps the pins_in value sampled at the edge where halted was set. When halt_req drops, halted clears at the next edge and pins_out follows pins_in again.
- R9: halt_req is also 1 whenever sw_halt is 1, and it reaches halted through the same boundary rule.
- R10: With the supervisor-only bit set, an access with bus_sup=0 gets no bus_ack, no periph_wr_en or periph_rd_en, and does not change the configuration word.
- R11: An access with bus_sup=1, or any access while the supervisor-only bit is 0, is acknowledged with bus_ack high for the one cycle after bus_sel. A running read of a non-configuration address returns the periph_rdata value present during the bus_sel cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sup | input | 1 | 1 = supervisor-mode access |
| bus_addr | input | ADDR_W | Word address within the peripheral |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after bus_sel |
| periph_rdata | input | 16 | Read data from the peripheral's registers and RAM |
| periph_wr_en | output | 1 | Forwarded write strobe |
| periph_rd_en | output | 1 | Forwarded read strobe |
| freeze_in | input | 1 | Debug freeze request |
| sw_halt | input | 1 | Software halt request |
| xfer_bnd | input | 1 | Serial engine is at a transfer boundary |
| pins_in | input | PIN_W | Serial output pin values from the engine |
| pins_out | output | PIN_W | Serial output pins, held while halted |
| clk_en | output | 1 | Clock enable for the peripheral logic |
| halt_req | output | 1 | Halt request to the serial engine |
| halted | output | 1 | Halt reached at a transfer boundary |

## Verification
The assertions assume that bus_sel lasts one cycle per access and that bus_sup, bus_wr, bus_addr and bus_wdata stay steady while bus_sel is high. They also assume that freeze_in, sw_halt and xfer_bnd are level signals sampled at the rising edge. The bench changes every input only at the falling edge and returns bus_sel to 0 between accesses, so each access is a single isolated cycle. The halt inputs are held for whole cycles across the boundary and release steps.

// File: rtl/pstop_pkg.sv
package pstop_pkg;
    localparam int CFG_W    = 16;
    localparam int STOP_POS = 15;
    localparam int FRZ_POS  = 14;
    localparam int SUP_POS  = 7;
    localparam int ARB_W    = 4;
    localparam logic [CFG_W-1:0] CFG_RESET = 16'h0080;

    typedef struct packed {
        logic             stop;
        logic             frz;
        logic             sup;
        logic [ARB_W-1:0] arb;
    } cfg_t;

    function automatic logic [CFG_W-1:0] cfg_pack(cfg_t c);
        logic [CFG_W-1:0] v;
        v            = '0;
        v[STOP_POS]  = c.stop;
        v[FRZ_POS]   = c.frz;
        v[SUP_POS]   = c.sup;
        v[ARB_W-1:0] = c.arb;
        return v;
    endfunction

    function automatic cfg_t cfg_unpack(logic [CFG_W-1:0] v);
        cfg_t c;
        c.stop = v[STOP_POS];
        c.frz  = v[FRZ_POS];
        c.sup  = v[SUP_POS];
        c.arb  = v[ARB_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pstop_cfg.sv
module pstop_cfg
    import pstop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = cfg_unpack(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= cfg_unpack(CFG_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;
endmodule

// File: rtl/pstop_access.sv
module pstop_access
    import pstop_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_sup,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CFG_W-1:0]  cfg_rdata,
    input  logic [CFG_W-1:0]  periph_rdata,
    input  logic              sup_only,
    input  logic              stopped,
    output logic              cfg_wr_en,
    output logic              periph_wr_en,
    output logic              periph_rd_en,
    output logic              bus_ack,
    output logic [CFG_W-1:0]  bus_rdata
);
    typedef struct packed {
        logic             ack;
        logic [CFG_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;
    logic   permit;
    logic   cfg_hit;

    always_comb begin
        permit       = bus_sel && (bus_sup || !sup_only);
        cfg_hit      = (bus_addr == CFG_ADDR);
        cfg_wr_en    = permit && bus_wr && cfg_hit;
        periph_wr_en = permit && bus_wr && !cfg_hit;
        periph_rd_en = permit && !bus_wr && !cfg_hit && !stopped;

        st_d       = st_q;
        st_d.ack   = permit;
        st_d.rdata = '0;
        if (permit && !bus_wr) begin
            if (cfg_hit) begin
                st_d.rdata = cfg_rdata;
            end else if (!stopped) begin
                st_d.rdata = periph_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ack   = st_q.ack;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/pstop_halt.sv
module pstop_halt #(
    parameter int PIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frz_en,
    input  logic             freeze_in,
    input  logic             sw_halt,
    input  logic             xfer_bnd,
    input  logic [PIN_W-1:0] pins_in,
    output logic             halt_req,
    output logic             halted,
    output logic [PIN_W-1:0] pins_out
);
    typedef struct packed {
        logic             halted;
        logic [PIN_W-1:0] held;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        halt_req = (frz_en && freeze_in) || sw_halt;
        st_d     = st_q;
        if (!halt_req) begin
            st_d.halted = 1'b0;
        end else if (xfer_bnd) begin
            st_d.halted = 1'b1;
        end
        if (!st_q.halted) begin
            st_d.held = pins_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted   = st_q.halted;
    assign pins_out = st_q.halted ? st_q.held : pins_in;
endmodule

// File: rtl/pstop_ctl.sv
module pstop_ctl
    import pstop_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter int                PIN_W    = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_sup,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CFG_W-1:0]  bus_wdata,
    output logic [CFG_W-1:0]  bus_rdata,
    output logic              bus_ack,
    input  logic [CFG_W-1:0]  periph_rdata,
    output logic              periph_wr_en,
    output logic              periph_rd_en,
    input  logic              freeze_in,
    input  logic              sw_halt,
    input  logic              xfer_bnd,
    input  logic [PIN_W-1:0]  pins_in,
    output logic [PIN_W-1:0]  pins_out,
    output logic              clk_en,
    output logic              halt_req,
    output logic              halted
);
    cfg_t cfg;
    logic cfg_wr_en;
    logic cfg_sup;
    logic cfg_frz;

    assign cfg_sup = cfg.sup;
    assign cfg_frz = cfg.frz;
    assign clk_en  = !cfg.stop;

    pstop_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    pstop_access #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_access (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_sup      (bus_sup),
        .bus_addr     (bus_addr),
        .cfg_rdata    (cfg_pack(cfg)),
        .periph_rdata (periph_rdata),
        .sup_only     (cfg.sup),
        .stopped      (cfg.stop),
        .cfg_wr_en    (cfg_wr_en),
        .periph_wr_en (periph_wr_en),
        .periph_rd_en (periph_rd_en),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata)
    );

    pstop_halt #(
        .PIN_W (PIN_W)
    ) u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .frz_en    (cfg.frz),
        .freeze_in (freeze_in),
        .sw_halt   (sw_halt),
        .xfer_bnd  (xfer_bnd),
        .pins_in   (pins_in),
        .halt_req  (halt_req),
        .halted    (halted),
        .pins_out  (pins_out)
    );
endmodule

// File: rtl/pstop_ctl_chk.sv
module pstop_ctl_chk #(
    parameter int                ADDR_W   = 6,
    parameter int                PIN_W    = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_sup,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack,
    input logic              periph_wr_en,
    input logic              periph_rd_en,
    input logic              sup_bit,
    input logic              frz_en,
    input logic              sw_halt,
    input logic              halt_req,
    input logic              halted,
    input logic              clk_en,
    input logic [PIN_W-1:0]  pins_out
);
    AST_STOP_GATES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == CFG_ADDR) && (bus_sup || !sup_bit))
        |=> (clk_en == !$past(bus_wdata[15]))); // R3

    AST_NO_READ_WHILE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !periph_rd_en); // R4

    AST_FREEZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_en && !sw_halt) |-> !halt_req); // R7

    AST_HALT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> $past(halt_req)); // R6

    AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(pins_out)); // R8

    AST_USER_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_sup && sup_bit) |=> !bus_ack); // R10

    AST_USER_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_sup && sup_bit) |-> !(periph_wr_en || periph_rd_en)); // R10

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (bus_sup || !sup_bit)) |=> bus_ack); // R11
endmodule

bind pstop_ctl pstop_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .PIN_W    (PIN_W),
    .CFG_ADDR (CFG_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_sup      (bus_sup),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack),
    .periph_wr_en (periph_wr_en),
    .periph_rd_en (periph_rd_en),
    .sup_bit      (cfg_sup),
    .frz_en       (cfg_frz),
    .sw_halt      (sw_halt),
    .halt_req     (halt_req),
    .halted       (halted),
    .clk_en       (clk_en),
    .pins_out     (pins_out)
);

// File: tb/pstop_ctl_tb.sv
module pstop_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int PIN_W      = 4;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic              sup;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
        logic              ack;
        logic [15:0]       rd;
        logic              pwr;
        logic              prd;
        logic              clken;
        logic [3:0]        req;
    } vec_t;

    // periph_rdata model: 16'hA500 | address
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 6'd0, 16'h0000, 1'b1, 16'h0080, 1'b0, 1'b0, 1'b1, 4'd1},  // R1
        '{1'b1, 1'b1, 6'd0, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 1'b0, 6'd0, 16'h0000, 1'b1, 16'hC08F, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 1'b0, 6'd5, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 1'b1, 6'd5, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{1'b1, 1'b1, 6'd0, 16'h0083, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{1'b1, 1'b0, 6'd5, 16'h0000, 1'b1, 16'hA505, 1'b0, 1'b1, 1'b1, 4'd11}, // R11
        '{1'b0, 1'b0, 6'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{1'b0, 1'b1, 6'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{1'b1, 1'b0, 6'd0, 16'h0000, 1'b1, 16'h0083, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{1'b1, 1'b1, 6'd0, 16'h0005, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
        '{1'b0, 1'b0, 6'd9, 16'h0000, 1'b1, 16'hA509, 1'b0, 1'b1, 1'b1, 4'd11}, // R11
        '{1'b0, 1'b1, 6'd0, 16'h0080, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd11}, // R11
        '{1'b1, 1'b0, 6'd0, 16'h0000, 1'b1, 16'h0080, 1'b0, 1'b0, 1'b1, 4'd2}   // R2
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_sup = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              bus_ack;
    logic [15:0]       periph_rdata;
    logic              periph_wr_en;
    logic              periph_rd_en;
    logic              freeze_in = 1'b0;
    logic              sw_halt = 1'b0;
    logic              xfer_bnd = 1'b0;
    logic [PIN_W-1:0]  pins_in = '0;
    logic [PIN_W-1:0]  pins_out;
    logic              clk_en;
    logic              halt_req;
    logic              halted;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign periph_rdata = 16'hA500 | {{(16-ADDR_W){1'b0}}, bus_addr};

    pstop_ctl #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_sup      (bus_sup),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_ack      (bus_ack),
        .periph_rdata (periph_rdata),
        .periph_wr_en (periph_wr_en),
        .periph_rd_en (periph_rd_en),
        .freeze_in    (freeze_in),
        .sw_halt      (sw_halt),
        .xfer_bnd     (xfer_bnd),
        .pins_in      (pins_in),
        .pins_out     (pins_out),
        .clk_en       (clk_en),
        .halt_req     (halt_req),
        .halted       (halted)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic sup, input logic wr, input logic [ADDR_W-1:0] addr,
                          input logic [15:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_sup = sup; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 clk_en after reset", clk_en, 1);
        chk("R1 halt_req after reset", halt_req, 0);
        chk("R1 halted after reset", halted, 0);
        chk("R1 bus_ack after reset", bus_ack, 0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_sup = VECS[i].sup; bus_wr = VECS[i].wr;
            bus_addr = VECS[i].addr; bus_wdata = VECS[i].wdata;
            #1;
            chk($sformatf("R%0d vec %0d periph_wr_en", VECS[i].req, i), periph_wr_en, VECS[i].pwr);
            chk($sformatf("R%0d vec %0d periph_rd_en", VECS[i].req, i), periph_rd_en, VECS[i].prd);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            chk($sformatf("R%0d vec %0d bus_ack", VECS[i].req, i), bus_ack, VECS[i].ack);
            if (!VECS[i].wr && VECS[i].ack)
                chk($sformatf("R%0d vec %0d bus_rdata", VECS[i].req, i), bus_rdata, VECS[i].rd);
            chk($sformatf("R%0d vec %0d clk_en", VECS[i].req, i), clk_en, VECS[i].clken);
        end

        // R6 / R8: freeze halt at boundary with pin hold
        bus_op(1'b1, 1'b1, '0, 16'h4080);
        freeze_in = 1'b1; pins_in = 4'h5; xfer_bnd = 1'b0;
        #1;
        chk("R6 halt_req on freeze", halt_req, 1);
        @(negedge clk);
        chk("R6 no halt before boundary", halted, 0);
        xfer_bnd = 1'b1;
        @(negedge clk);
        chk("R6 halted at boundary", halted, 1);
        xfer_bnd = 1'b0; pins_in = 4'hA;
        #1;
        chk("R8 pins held", pins_out, 4'h5);
        @(negedge clk);
        chk("R6 halted stays", halted, 1);
        chk("R8 pins still held", pins_out, 4'h5);
        freeze_in = 1'b0;
        #1;
        chk("R8 halt_req drops", halt_req, 0);
        @(negedge clk);
        chk("R8 resumes", halted, 0);
        chk("R8 pins follow", pins_out, 4'hA);

        // R7: freeze ignored when disabled
        bus_op(1'b1, 1'b1, '0, 16'h0080);
        freeze_in = 1'b1; xfer_bnd = 1'b1;
        #1;
        chk("R7 halt_req ignored", halt_req, 0);
        @(negedge clk);
        chk("R7 halted ignored", halted, 0);
        pins_in = 4'h3;
        #1;
        chk("R7 pins pass", pins_out, 4'h3);
        freeze_in = 1'b0; xfer_bnd = 1'b0;

        // R9: software halt
        @(negedge clk);
        sw_halt = 1'b1;
        #1;
        chk("R9 halt_req from sw_halt", halt_req, 1);
        xfer_bnd = 1'b1;
        @(negedge clk);
        chk("R9 halted from sw_halt", halted, 1);
        sw_halt = 1'b0; xfer_bnd = 1'b0;
        @(negedge clk);
        chk("R9 released", halted, 0);

        // R1 / R3: reset clears a set stop bit
        bus_op(1'b1, 1'b1, '0, 16'h800F);
        chk("R3 stop set", clk_en, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R3 clk_en after reset", clk_en, 1);
        bus_op(1'b1, 1'b0, '0, 16'h0000);
        chk("R1 cfg after reset ack", bus_ack, 1);
        chk("R1 cfg after reset", bus_rdata, 16'h0080);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule